// File: doc/BRIEF.md
# Power Mode Transition Controller

This block steps a microcontroller core between its operating modes: active at full speed, active at a reduced speed (system clock divided by eight), and a low-speed subactive mode that runs from a slow secondary clock. A short watch state is inserted whenever subactive mode is entered or left. The controller runs on the oscillator clock. A one-cycle sleep request samples five control bits: standby enable, low-speed select, medium-speed select, direct-transfer enable and watch-timer source select. It also samples a 3-bit settling-time selector. From these and the current mode it decodes whether a direct transition is allowed, and which mode it leads to.

An accepted transition runs in three phases. The first phase covers the sleep-instruction states and the internal processing states, counted in periods of the old system clock. An optional watch phase follows; when the oscillator is being restarted it lasts for the selected settling time. The last phase covers the interrupt exception handling states, counted in periods of the new system clock. The clock-select output switches at the start of the last phase. At the end, a one-cycle done strobe starts exception handling and the total transition time in oscillator cycles is published. A request whose bits match no legal transition leaves the mode unchanged and raises a one-cycle ignored flag.

Top module: `pmt_ctrl`

## Requirements
- R1: After reset, `mode_o` and `clk_sel_o` are 0 (full speed), and `xfer_done`, `req_ignored` and `xfer_time` are 0. Mode and clock-select encoding: 0 = full speed, 1 = medium speed, 2 = subactive.
- R2: From full speed, a request with standby=0, low-speed=0, medium-speed=1 and direct=1 moves directly to medium speed. With default parameters it takes 3×2 + 14×16 = 230 oscillator cycles.
- R3: From medium speed, a request with standby=0, low-speed=0, medium-speed=0 and direct=1 moves directly to full speed in 3×16 + 14×2 = 76 cycles.
- R4: From medium speed, a request with standby=1, low-speed=1, direct=1 and watch-source=1 (medium-speed bit ignored) moves to subactive through a one-cycle watch phase: 3×16 + 1 + 14×SUB_DIV cycles.
- R5: From subactive, a request with standby=1, low-speed=0, medium-speed=1, direct=1 and watch-source=1 moves to medium speed. The watch phase lasts SETTLE_BASE shifted left by the 3-bit selector, giving 3×SUB_DIV + (SETTLE_BASE<<sel) + 14×16 cycles.
- R6: `clk_sel_o` changes exactly once per transition, to the target mode's code. It changes on the edge that ends the old-clock phase, or the watch phase when there is one.
- R7: `xfer_done` is a one-cycle pulse. `mode_o` takes the target value on the same edge, and `xfer_time` then holds the number of cycles from the accepting edge to that edge.
- R8: A request in idle whose bits match none of the combinations above leaves `mode_o` and `clk_sel_o` unchanged. It produces no done pulse and raises `req_ignored` for exactly one cycle.
- R9: Target, path and settling selector are latched when a request is accepted. Changes of the control inputs, and further sleep requests, during a transition do not change its result. They raise no ignored flag and start no second transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle sleep request |
| stby_en | input | 1 | Standby enable bit |
| lowspd_sel | input | 1 | Low-speed select bit |
| medspd_sel | input | 1 | Medium-speed select bit |
| direct_en | input | 1 | Direct-transfer enable bit |
| wtimer_src | input | 1 | Watch-timer source select bit |
| settle_sel | input | 3 | Settling-time selector |
| mode_o | output | 2 | Current operating mode |
| clk_sel_o | output | 2 | System clock divider select |
| xfer_done | output | 1 | Transition complete strobe |
| req_ignored | output | 1 | Request matched no transition |
| xfer_time | output | CNT_W | Cycles taken by the last transition |

## Verification
A request is accepted on the clock edge where `sleep_req` is high. The ignored flag is due one edge later. The done strobe, the new mode and the time value are due exactly T edges after acceptance, where T is the sum of the phase lengths. The clock select is due after the old-clock phase plus any watch phase. The bench drives inputs on falling edges and counts falling edges from the request. It checks that the done strobe first appears at count T+1 and the clock-select change at count old+watch+1. The expected counts are computed from the state counts and divider ratios in the requirements.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [1:0] {
        MODE_HS  = 2'd0,
        MODE_MS  = 2'd1,
        MODE_SUB = 2'd2
    } pm_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OLD   = 2'd1,
        PH_WATCH = 2'd2,
        PH_NEW   = 2'd3
    } pm_phase_e;

    typedef struct packed {
        logic stby;
        logic lowspd;
        logic medspd;
        logic direct;
        logic wsrc;
    } pm_ctrl_t;

endpackage

// File: rtl/pmt_decode.sv
module pmt_decode
    import pmt_pkg::*;
(
    input  pm_mode_e cur_i,
    input  pm_ctrl_t ctrl_i,
    output logic     valid_o,
    output pm_mode_e tgt_o,
    output logic     via_watch_o
);
    always_comb begin
        valid_o     = 1'b0;
        tgt_o       = cur_i;
        via_watch_o = 1'b0;
        unique case (cur_i)
            MODE_HS: begin
                if (!ctrl_i.stby && !ctrl_i.lowspd && ctrl_i.medspd && ctrl_i.direct) begin
                    valid_o = 1'b1;
                    tgt_o   = MODE_MS;
                end
            end
            MODE_MS: begin
                if (!ctrl_i.stby && !ctrl_i.lowspd && !ctrl_i.medspd && ctrl_i.direct) begin
                    valid_o = 1'b1;
                    tgt_o   = MODE_HS;
                end else if (ctrl_i.stby && ctrl_i.lowspd && ctrl_i.direct && ctrl_i.wsrc) begin
                    valid_o     = 1'b1;
                    tgt_o       = MODE_SUB;
                    via_watch_o = 1'b1;
                end
            end
            MODE_SUB: begin
                if (ctrl_i.stby && !ctrl_i.lowspd && ctrl_i.medspd && ctrl_i.direct && ctrl_i.wsrc) begin
                    valid_o     = 1'b1;
                    tgt_o       = MODE_MS;
                    via_watch_o = 1'b1;
                end
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pmt_phase_len.sv
module pmt_phase_len
    import pmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int HS_DIV  = 2,
    parameter int MS_DIV  = 16,
    parameter int SUB_DIV = 64,
    parameter int STATES  = 3
) (
    input  pm_mode_e         mode_i,
    output logic [CNT_W-1:0] len_o
);
    localparam logic [CNT_W-1:0] LEN_HS  = CNT_W'(STATES * HS_DIV);
    localparam logic [CNT_W-1:0] LEN_MS  = CNT_W'(STATES * MS_DIV);
    localparam logic [CNT_W-1:0] LEN_SUB = CNT_W'(STATES * SUB_DIV);

    always_comb begin
        unique case (mode_i)
            MODE_HS:  len_o = LEN_HS;
            MODE_MS:  len_o = LEN_MS;
            MODE_SUB: len_o = LEN_SUB;
            default:  len_o = LEN_HS;
        endcase
    end
endmodule

// File: rtl/pmt_settle_lut.sv
module pmt_settle_lut #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3,
    parameter int BASE  = 16
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int ENTRIES = 1 << SEL_W;

    logic [CNT_W-1:0] table_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign table_w[g] = CNT_W'(BASE << g);
    end

    assign cnt_o = table_w[sel_i];
endmodule

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
    import pmt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int HS_DIV      = 2,
    parameter int MS_DIV      = 16,
    parameter int SUB_DIV     = 64,
    parameter int SLEEP_ST    = 2,
    parameter int INTERN_ST   = 1,
    parameter int EXC_ST      = 14,
    parameter int SETTLE_BASE = 16,
    parameter int SEL_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             stby_en,
    input  logic             lowspd_sel,
    input  logic             medspd_sel,
    input  logic             direct_en,
    input  logic             wtimer_src,
    input  logic [SEL_W-1:0] settle_sel,
    output logic [1:0]       mode_o,
    output logic [1:0]       clk_sel_o,
    output logic             xfer_done,
    output logic             req_ignored,
    output logic [CNT_W-1:0] xfer_time
);
    localparam int               PRE_ST = SLEEP_ST + INTERN_ST;
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    typedef struct packed {
        pm_phase_e        ph;
        pm_mode_e         mode;
        pm_mode_e         csel;
        pm_mode_e         tgt;
        logic             via;
        logic [SEL_W-1:0] ssel;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] elap;
        logic [CNT_W-1:0] tim;
        logic             done;
        logic             ign;
    } ctrl_state_t;

    ctrl_state_t st_q, st_d;

    pm_ctrl_t         ctrl_w;
    logic             dec_valid;
    pm_mode_e         dec_tgt;
    logic             dec_via;
    logic [CNT_W-1:0] old_len;
    logic [CNT_W-1:0] new_len;
    logic [CNT_W-1:0] settle_len;
    logic [CNT_W-1:0] watch_len;

    assign ctrl_w = '{stby: stby_en, lowspd: lowspd_sel, medspd: medspd_sel,
                      direct: direct_en, wsrc: wtimer_src};

    pmt_decode u_decode (
        .cur_i       (st_q.mode),
        .ctrl_i      (ctrl_w),
        .valid_o     (dec_valid),
        .tgt_o       (dec_tgt),
        .via_watch_o (dec_via)
    );

    pmt_phase_len #(
        .CNT_W(CNT_W), .HS_DIV(HS_DIV), .MS_DIV(MS_DIV), .SUB_DIV(SUB_DIV), .STATES(PRE_ST)
    ) u_old_len (
        .mode_i (st_q.mode),
        .len_o  (old_len)
    );

    pmt_phase_len #(
        .CNT_W(CNT_W), .HS_DIV(HS_DIV), .MS_DIV(MS_DIV), .SUB_DIV(SUB_DIV), .STATES(EXC_ST)
    ) u_new_len (
        .mode_i (st_q.tgt),
        .len_o  (new_len)
    );

    pmt_settle_lut #(
        .CNT_W(CNT_W), .SEL_W(SEL_W), .BASE(SETTLE_BASE)
    ) u_settle (
        .sel_i (st_q.ssel),
        .cnt_o (settle_len)
    );

    // Entering subactive needs no restart wait; leaving it waits for the oscillator.
    assign watch_len = (st_q.tgt == MODE_SUB) ? ONE : settle_len;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.ign  = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (sleep_req) begin
                    if (dec_valid) begin
                        st_d.ph   = PH_OLD;
                        st_d.tgt  = dec_tgt;
                        st_d.via  = dec_via;
                        st_d.ssel = settle_sel;
                        st_d.cnt  = old_len;
                        st_d.elap = '0;
                    end else begin
                        st_d.ign = 1'b1;
                    end
                end
            end
            PH_OLD: begin
                st_d.elap = st_q.elap + ONE;
                if (st_q.cnt <= ONE) begin
                    if (st_q.via) begin
                        st_d.ph  = PH_WATCH;
                        st_d.cnt = watch_len;
                    end else begin
                        st_d.ph   = PH_NEW;
                        st_d.cnt  = new_len;
                        st_d.csel = st_q.tgt;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_WATCH: begin
                st_d.elap = st_q.elap + ONE;
                if (st_q.cnt <= ONE) begin
                    st_d.ph   = PH_NEW;
                    st_d.cnt  = new_len;
                    st_d.csel = st_q.tgt;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            PH_NEW: begin
                st_d.elap = st_q.elap + ONE;
                if (st_q.cnt <= ONE) begin
                    st_d.ph   = PH_IDLE;
                    st_d.mode = st_q.tgt;
                    st_d.done = 1'b1;
                    st_d.tim  = st_q.elap + ONE;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, mode: MODE_HS, csel: MODE_HS, tgt: MODE_HS,
                      via: 1'b0, ssel: '0, cnt: '0, elap: '0, tim: '0,
                      done: 1'b0, ign: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o      = st_q.mode;
    assign clk_sel_o   = st_q.csel;
    assign xfer_done   = st_q.done;
    assign req_ignored = st_q.ign;
    assign xfer_time   = st_q.tim;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    assert_mode_moves_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> xfer_done);

    assert_ignore_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ignored |-> (!xfer_done && $stable(mode_o) && $stable(clk_sel_o)));

    assert_clk_switch_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel_o) |-> (st_q.ph == PH_NEW && clk_sel_o == st_q.tgt));

    assert_ignore_only_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ignored |-> $past(st_q.ph == PH_IDLE));

endmodule

// File: tb/pmt_ctrl_test.sv
module pmt_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int SBASE      = 4;
    localparam int LIMIT      = 5000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic [4:0]       bits = 5'b0;
    logic [2:0]       settle_sel = 3'd0;
    logic [1:0]       mode_o, clk_sel_o;
    logic             xfer_done, req_ignored;
    logic [CNT_W-1:0] xfer_time;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmt_ctrl #(.CNT_W(CNT_W), .SETTLE_BASE(SBASE)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .stby_en(bits[4]), .lowspd_sel(bits[3]), .medspd_sel(bits[2]),
        .direct_en(bits[1]), .wtimer_src(bits[0]), .settle_sel(settle_sel),
        .mode_o(mode_o), .clk_sel_o(clk_sel_o), .xfer_done(xfer_done),
        .req_ignored(req_ignored), .xfer_time(xfer_time)
    );

    // {bits[5], sel[3], exp_mode[2], ignored[1], total T[16], clk_sel count[16]}
    localparam logic [42:0] VEC [10] = '{
        {5'b00110, 3'd0, 2'd1, 1'b0, 16'd230, 16'd7},
        {5'b10010, 3'd0, 2'd1, 1'b1, 16'd0,   16'd0},
        {5'b00010, 3'd0, 2'd0, 1'b0, 16'd76,  16'd49},
        {5'b00100, 3'd0, 2'd0, 1'b1, 16'd0,   16'd0},
        {5'b00110, 3'd0, 2'd1, 1'b0, 16'd230, 16'd7},
        {5'b11011, 3'd5, 2'd2, 1'b0, 16'd945, 16'd50},
        {5'b10111, 3'd2, 2'd1, 1'b0, 16'd432, 16'd209},
        {5'b11111, 3'd0, 2'd2, 1'b0, 16'd945, 16'd50},
        {5'b10111, 3'd0, 2'd1, 1'b0, 16'd420, 16'd197},
        {5'b00010, 3'd0, 2'd0, 1'b0, 16'd76,  16'd49}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Issues one request and counts falling edges until done or ignored.
    task automatic run_req(input logic [4:0] b, input logic [2:0] s, input bit disturb,
                           output int n_end, output int n_cs, output int cs_changes,
                           output bit saw_ign);
        logic [1:0] prev_cs;
        @(negedge clk);
        bits = b;
        settle_sel = s;
        sleep_req = 1'b1;
        prev_cs = clk_sel_o;
        n_end = 0; n_cs = 0; cs_changes = 0; saw_ign = 1'b0;
        do begin
            @(negedge clk);
            n_end++;
            if (n_end == 1) sleep_req = 1'b0;
            if (disturb && n_end == 3) begin
                bits = 5'b01001;
                settle_sel = ~s;
                sleep_req = 1'b1;
            end
            if (disturb && n_end == 4) sleep_req = 1'b0;
            if (clk_sel_o != prev_cs) begin
                cs_changes++;
                if (n_cs == 0) n_cs = n_end;
                prev_cs = clk_sel_o;
            end
            if (req_ignored) saw_ign = 1'b1;
        end while (!xfer_done && !req_ignored && n_end < LIMIT);
    endtask

    task automatic check_valid(input string req, input int t_exp, input int cs_exp,
                               input int mode_exp, input int n_end, input int n_cs,
                               input int cs_changes, input bit saw_ign);
        check({req, " done delay"}, n_end, t_exp + 1);
        check({req, " xfer_time"}, int'(xfer_time), t_exp);
        check({req, " mode"}, int'(mode_o), mode_exp);
        check({req, " clk_sel value"}, int'(clk_sel_o), mode_exp);
        check({req, " clk_sel switch"}, n_cs, cs_exp);
        check({req, " clk_sel once R6"}, cs_changes, 1);
        check({req, " no ignored"}, int'(saw_ign), 0);
        @(negedge clk);
        check({req, " done pulse R7"}, int'(xfer_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n_end, n_cs, cs_changes;
        bit saw_ign;
        int pre_mode;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode", int'(mode_o), 0);
        check("R1 clk_sel", int'(clk_sel_o), 0);
        check("R1 done", int'(xfer_done), 0);
        check("R1 ignored", int'(req_ignored), 0);
        check("R1 time", int'(xfer_time), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R2 R3 R4 R5 R8 covered by the entries
        for (int i = 0; i < 10; i++) begin
            logic [42:0] v;
            v = VEC[i];
            pre_mode = int'(mode_o);
            run_req(v[42:38], v[37:35], 1'b0, n_end, n_cs, cs_changes, saw_ign);
            if (v[32]) begin
                check($sformatf("R8 vec%0d ignored flag", i), int'(req_ignored), 1);
                check($sformatf("R8 vec%0d mode kept", i), int'(mode_o), pre_mode);
                check($sformatf("R8 vec%0d no done", i), int'(xfer_done), 0);
                @(negedge clk);
                check($sformatf("R8 vec%0d flag one cycle", i), int'(req_ignored), 0);
                check($sformatf("R8 vec%0d clk_sel kept", i), int'(clk_sel_o), pre_mode);
            end else begin
                check_valid($sformatf("R2-5 vec%0d", i), int'(v[31:16]), int'(v[15:0]),
                            int'(v[34:33]), n_end, n_cs, cs_changes, saw_ign);
            end
        end

        // R8: subactive-entry bits are illegal from full speed
        run_req(5'b11011, 3'd0, 1'b0, n_end, n_cs, cs_changes, saw_ign);
        check("R8 HS with sub bits ignored", int'(req_ignored), 1);
        check("R8 HS with sub bits mode", int'(mode_o), 0);

        // R9: inputs and a second request change mid-flight; result unchanged
        run_req(5'b00110, 3'd0, 1'b1, n_end, n_cs, cs_changes, saw_ign);
        check_valid("R9 HS->MS disturbed", 230, 7, 1, n_end, n_cs, cs_changes, saw_ign);
        repeat (20) @(negedge clk);
        check("R9 no second transition mode", int'(mode_o), 1);
        check("R9 no second transition clk", int'(clk_sel_o), 1);

        // R4 then R5 with the largest settling selector, selector disturbed
        run_req(5'b11011, 3'd0, 1'b0, n_end, n_cs, cs_changes, saw_ign);
        check_valid("R4 MS->SUB", 945, 50, 2, n_end, n_cs, cs_changes, saw_ign);
        run_req(5'b10111, 3'd7, 1'b1, n_end, n_cs, cs_changes, saw_ign);
        check_valid("R5 R9 SUB->MS sel7", 192 + (SBASE << 7) + 224,
                    192 + (SBASE << 7) + 1, 1, n_end, n_cs, cs_changes, saw_ign);

        finish_run();
    end
endmodule